// File: doc/BRIEF.md
# Floating-point compare store hazard NOP inserter

This block sits between instruction fetch and decode in a 32-bit SPARC-style integer pipeline. It watches the in-order instruction stream for one particular pattern. The pattern is a floating-point compare, followed at once by one of nine integer operations, followed by a floating-point double store. On some pipelines that pattern writes the compare's program counter to memory in place of the upper data word. The floating-point register file itself stays intact. The block breaks the pattern by placing a single NOP between the compare and the integer operation.

The block works conservatively. It inserts the NOP as soon as a compare is directly followed by a listed integer operation, without looking at the third instruction. A one-bit history records whether the last word placed on the output was a compare. This history stands in for holding the compare itself, so no latency is added.

Words enter and leave through valid/ready handshakes, with one registered output stage. The upstream stage is held off for exactly one cycle per inserted NOP. A flush input, raised on a branch or trap, drops the staged word and forgets the history.

Top module: `fcmp_hazard_guard`

## Requirements
- R1: While reset is active, and until the internal synchronised reset releases, `in_ready` is 0 and `out_valid` is 0. Once running with an empty output stage, `in_ready` is 1 and `out_valid` is 0.
- R2: A word is a compare when bits [31:30] = 2'b10, bits [24:19] = 6'h35 and bits [13:5] is one of 9'h051, 9'h055, 9'h052 or 9'h056. Any other value in bits [13:5] is not a compare.
- R3: A word is a listed integer operation when bits [31:30] = 2'b10 and bits [24:19] is one of 6'h02, 6'h12, 6'h06, 6'h16, 6'h26, 6'h22, 6'h3A, 6'h2A or 6'h32, whatever the other bits hold.
- R4: When a listed integer operation arrives and the word just before it in the output stream was a compare, the block emits exactly one NOP (32'h0100_0000) first. During the cycle the NOP is loaded, `in_ready` is 0. The integer operation then passes unchanged.
- R5: Insertion does not depend on the word after the integer operation. A compare and integer operation pair gets its NOP whether a double store, another instruction or nothing follows.
- R6: If any word lies between the compare and the integer operation (a NOP included), or if the middle word is not a listed operation, the stream passes unchanged.
- R7: An inserted NOP clears the history. Compare, compare, integer operation yields a single NOP, placed after the second compare.
- R8: A cycle with `flush` high holds `in_ready` at 0, empties the output stage on the next cycle and clears the history. When flush coincides with a pending insertion, flush wins: no NOP follows, and the integer operation is later accepted without one.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds steady. Under any output back-pressure every accepted word leaves exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| flush | input | 1 | Branch or trap flush; drops the staged word and the history |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | 32 | Upstream instruction word |
| in_ready | output | 1 | Block can take the upstream word this cycle |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output instruction word |
| out_ready | input | 1 | Downstream takes the output word |

## Verification
Two events can fall in the same cycle: an insertion decision, and either output back-pressure or a flush.

A hazardous integer operation can arrive while the staged compare is still stalled downstream. Random `out_ready` provokes this case, and the output sequence is compared word for word against a model of the stream rule.

A flush can also be raised in exactly the cycle a hazardous integer operation is presented. That case is judged by `in_ready` being low in the flush cycle, and by the operation later emerging with no NOP in front of it.

// File: rtl/fhg_pkg.sv
package fhg_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned N_FCMP = 4;
  localparam int unsigned N_IUOP = 9;
  localparam logic [INSN_W-1:0] NOP_WORD = 32'h0100_0000;

  localparam logic [1:0] OP_ARITH = 2'b10;
  localparam logic [5:0] OP3_FPCMP = 6'h35;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_FCMP  = 2'd1,
    KIND_IUOP  = 2'd2
  } kind_e;

  // opf codes of the four compare flavours
  function automatic logic [8:0] fcmp_opf(input int unsigned idx);
    case (idx)
      0:       return 9'h051;
      1:       return 9'h055;
      2:       return 9'h052;
      default: return 9'h056;
    endcase
  endfunction

  // op3 codes of the integer operations that complete the hazard
  function automatic logic [5:0] iuop_op3(input int unsigned idx);
    case (idx)
      0:       return 6'h02;
      1:       return 6'h12;
      2:       return 6'h06;
      3:       return 6'h16;
      4:       return 6'h26;
      5:       return 6'h22;
      6:       return 6'h3A;
      7:       return 6'h2A;
      default: return 6'h32;
    endcase
  endfunction

  // behavioural classifier, used by the checker only
  function automatic kind_e classify(input logic [INSN_W-1:0] w);
    kind_e k;
    k = KIND_OTHER;
    if (w[31:30] == OP_ARITH) begin
      if (w[24:19] == OP3_FPCMP) begin
        for (int unsigned i = 0; i < N_FCMP; i++)
          if (w[13:5] == fcmp_opf(i)) k = KIND_FCMP;
      end else begin
        for (int unsigned i = 0; i < N_IUOP; i++)
          if (w[24:19] == iuop_op3(i)) k = KIND_IUOP;
      end
    end
    return k;
  endfunction

endpackage

// File: rtl/fhg_decode.sv
module fhg_decode
  import fhg_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output kind_e             kind
);

  logic [1:0]        fld_op;
  logic [5:0]        fld_op3;
  logic [8:0]        fld_opf;
  logic [N_FCMP-1:0] opf_hit;
  logic [N_IUOP-1:0] op3_hit;

  assign fld_op  = word[31:30];
  assign fld_op3 = word[24:19];
  assign fld_opf = word[13:5];

  for (genvar g = 0; g < N_FCMP; g++) begin : g_opf
    assign opf_hit[g] = (fld_opf == fcmp_opf(g));
  end

  for (genvar g = 0; g < N_IUOP; g++) begin : g_op3
    assign op3_hit[g] = (fld_op3 == iuop_op3(g));
  end

  always_comb begin
    kind = KIND_OTHER;
    if (fld_op == OP_ARITH) begin
      if ((fld_op3 == OP3_FPCMP) && (|opf_hit)) begin
        kind = KIND_FCMP;
      end else if (|op3_hit) begin
        kind = KIND_IUOP;
      end
    end
  end

endmodule

// File: rtl/fhg_track.sv
module fhg_track
  import fhg_pkg::*;
(
  input  logic  clk,
  input  logic  srst_n,
  input  logic  run,
  input  logic  flush,
  input  logic  in_valid,
  input  kind_e in_kind,
  input  logic  slot_free,
  output logic  inject,
  output logic  in_ready,
  output logic  load
);

  logic prev_fcmp_q;
  logic prev_fcmp_d;
  logic prev_en;

  // insertion decision: a listed integer op right after a compare
  assign inject   = run && !flush && in_valid &&
                    (in_kind == KIND_IUOP) && prev_fcmp_q;
  assign load     = run && !flush && slot_free && in_valid;
  assign in_ready = run && !flush && slot_free && !inject;

  always_comb begin
    prev_en     = 1'b0;
    prev_fcmp_d = prev_fcmp_q;
    if (flush) begin
      prev_en     = 1'b1;
      prev_fcmp_d = 1'b0;
    end else if (load) begin
      prev_en     = 1'b1;
      prev_fcmp_d = !inject && (in_kind == KIND_FCMP);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prev_fcmp_q <= 1'b0;
    end else if (prev_en) begin
      prev_fcmp_q <= prev_fcmp_d;
    end
  end

endmodule

// File: rtl/fhg_stage.sv
module fhg_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             flush,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             slot_free
);

  logic             valid_q;
  logic             valid_d;
  logic [WIDTH-1:0] data_q;

  assign slot_free = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_comb begin
    valid_d = valid_q;
    if (flush) begin
      valid_d = 1'b0;
    end else if (load) begin
      valid_d = 1'b1;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // data register: enable only, no reset needed
  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= load_data;
    end
  end

endmodule

// File: rtl/fcmp_hazard_guard.sv
module fcmp_hazard_guard
  import fhg_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [INSN_W-1:0] out_data,
  input  logic              out_ready
);

  localparam int unsigned SYNC_W = (RST_STAGES < 1) ? 1 : RST_STAGES;

  logic [SYNC_W-1:0] rst_pipe_q;
  logic              srst_n;
  logic              slot_free;
  logic              inject;
  logic              load;
  kind_e             in_kind;
  logic [INSN_W-1:0] load_data;

  // reset: asserted asynchronously, released on a clock edge
  if (SYNC_W == 1) begin : g_sync1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_pipe_q <= 1'b0;
      else        rst_pipe_q <= 1'b1;
    end
  end else begin : g_syncn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_pipe_q <= '0;
      else        rst_pipe_q <= {rst_pipe_q[SYNC_W-2:0], 1'b1};
    end
  end

  assign srst_n = rst_pipe_q[SYNC_W-1];

  fhg_decode u_decode (
    .word (in_data),
    .kind (in_kind)
  );

  fhg_track u_track (
    .clk       (clk),
    .srst_n    (srst_n),
    .run       (srst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_kind   (in_kind),
    .slot_free (slot_free),
    .inject    (inject),
    .in_ready  (in_ready),
    .load      (load)
  );

  assign load_data = inject ? NOP_WORD : in_data;

  fhg_stage #(.WIDTH(INSN_W)) u_stage (
    .clk       (clk),
    .srst_n    (srst_n),
    .flush     (flush),
    .load      (load),
    .load_data (load_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .slot_free (slot_free)
  );

endmodule

// File: rtl/fhg_checker.sv
module fhg_checker
  import fhg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [INSN_W-1:0] out_data,
  input logic              out_ready
);

  logic seen_fcmp_q;
  logic out_fire;

  assign out_fire = out_valid && out_ready;

  // last word that actually left the block was a compare
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_fcmp_q <= 1'b0;
    end else if (flush) begin
      seen_fcmp_q <= 1'b0;
    end else if (out_fire) begin
      seen_fcmp_q <= (classify(out_data) == KIND_FCMP);
    end
  end

  a_r1_idle_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!in_ready && !out_valid));

  a_r4_never_raw_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && classify(out_data) == KIND_IUOP) |-> !seen_fcmp_q);

  a_r4_stall_loads_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_valid && !in_ready && !flush)
    |=> (out_valid && out_data == NOP_WORD));

  a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

endmodule

bind fcmp_hazard_guard fhg_checker u_fhg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready)
);

// File: tb/fcmp_hazard_guard_tb_top.sv
`timescale 1ns/1ps
module fcmp_hazard_guard_tb_top;

  localparam logic [31:0] NOP = 32'h0100_0000;

  logic        clk;
  logic        rst_n;
  logic        flush;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready;

  int checks;
  int errors;
  int cyc;

  logic [31:0] stim [0:511];
  logic [31:0] expw [0:1023];
  logic [31:0] got  [0:1023];
  int n_stim;
  int n_exp;
  int n_got;

  fcmp_hazard_guard dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [8:0] b_opf(input int i);
    logic [8:0] t [0:3];
    t[0] = 9'h051; t[1] = 9'h055; t[2] = 9'h052; t[3] = 9'h056;
    return t[i];
  endfunction

  function automatic logic [5:0] b_op3(input int i);
    logic [5:0] t [0:8];
    t[0] = 6'h02; t[1] = 6'h12; t[2] = 6'h06; t[3] = 6'h16; t[4] = 6'h26;
    t[5] = 6'h22; t[6] = 6'h3A; t[7] = 6'h2A; t[8] = 6'h32;
    return t[i];
  endfunction

  function automatic logic [31:0] mk_fcmp(input int i);
    return {2'b10, 5'($urandom), 6'h35, 5'($urandom), b_opf(i), 5'($urandom)};
  endfunction

  function automatic logic [31:0] mk_alu(input logic [5:0] op3);
    return {2'b10, 5'($urandom), op3, 5'($urandom), 14'($urandom)};
  endfunction

  function automatic logic [31:0] mk_stdf();
    return {2'b11, 5'($urandom), 6'h27, 5'($urandom), 1'b1, 13'($urandom)};
  endfunction

  function automatic bit b_is_fcmp(input logic [31:0] w);
    bit r;
    r = 0;
    for (int i = 0; i < 4; i++)
      if (w[31:30] == 2'b10 && w[24:19] == 6'h35 && w[13:5] == b_opf(i)) r = 1;
    return r;
  endfunction

  function automatic bit b_is_iu(input logic [31:0] w);
    bit r;
    r = 0;
    for (int i = 0; i < 9; i++)
      if (w[31:30] == 2'b10 && w[24:19] == b_op3(i)) r = 1;
    return r;
  endfunction

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] d, input logic r,
                      input logic f, output logic acc);
    in_valid  = v;
    in_data   = d;
    out_ready = r;
    flush     = f;
    #1;
    acc = v && in_ready;
    if (out_valid && r && n_got < 1024) begin
      got[n_got] = out_data;
      n_got++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic build_exp();
    bit prev;
    prev  = 0;
    n_exp = 0;
    for (int i = 0; i < n_stim; i++) begin
      if (prev && b_is_iu(stim[i])) begin
        expw[n_exp] = NOP;
        n_exp++;
      end
      expw[n_exp] = stim[i];
      n_exp++;
      prev = b_is_fcmp(stim[i]);
    end
  endtask

  task automatic run_stream(input int bp, input string req, input string what);
    int   idx;
    int   guard;
    logic acc;
    logic rdy;
    int   bad;
    build_exp();
    n_got = 0;
    idx   = 0;
    guard = 0;
    while ((idx < n_stim || n_got < n_exp) && guard < 20000) begin
      rdy = (bp == 0) ? 1'b1 : (($urandom % 100) >= bp);
      step(idx < n_stim, (idx < n_stim) ? stim[idx] : 32'h0, rdy, 1'b0, acc);
      if (acc) idx++;
      guard++;
    end
    step(1'b0, 32'h0, 1'b1, 1'b1, acc);
    bad = -1;
    for (int i = 0; i < n_exp; i++)
      if (bad < 0 && (i >= n_got || got[i] !== expw[i])) bad = i;
    if (n_got != n_exp)
      chk(0, req, {what, " word count"}, 32'(n_got), 32'(n_exp));
    else if (bad >= 0)
      chk(0, req, {what, " word mismatch"}, got[bad], expw[bad]);
    else
      chk(1, req, what, 0, 0);
  endtask

  initial begin
    logic acc;
    int   n0;
    checks    = 0;
    errors    = 0;
    cyc       = 0;
    rst_n     = 1'b0;
    flush     = 1'b0;
    in_valid  = 1'b0;
    in_data   = 32'h0;
    out_ready = 1'b0;
    n_got     = 0;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(!in_ready, "R1", "in_ready in reset", 32'(in_ready), 0);
    chk(!out_valid, "R1", "out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(in_ready, "R1", "in_ready after reset", 32'(in_ready), 1);
    chk(!out_valid, "R1", "out_valid after reset", 32'(out_valid), 0);
    @(negedge clk);

    // R2 R3 R4: every compare with every listed op, then double store
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 9; m++) begin
        stim[0] = mk_fcmp(c);
        stim[1] = mk_alu(b_op3(m));
        stim[2] = mk_stdf();
        n_stim  = 3;
        run_stream((m % 2) * 50, "R4", $sformatf("hazard cmp%0d op%0d", c, m));
        chk(n_got == 4 && got[1] == NOP, "R4", "single NOP second", got[1], NOP);
      end
    end

    // R5: no store after the pair, and nothing at all
    stim[0] = mk_fcmp(1); stim[1] = mk_alu(6'h22); stim[2] = mk_alu(6'h00);
    n_stim = 3;
    run_stream(0, "R5", "pair then add");
    stim[0] = mk_fcmp(3); stim[1] = mk_alu(6'h3A);
    n_stim = 2;
    run_stream(30, "R5", "pair at stream end");
    chk(n_got == 3 && got[1] == NOP, "R5", "NOP at stream end", got[1], NOP);

    // R6: gap instructions and other middle ops
    stim[0] = mk_fcmp(0); stim[1] = mk_alu(6'h00); stim[2] = mk_alu(6'h02);
    stim[3] = mk_stdf(); n_stim = 4;
    run_stream(0, "R6", "add gap");
    chk(n_got == 4, "R6", "gap no NOP count", 32'(n_got), 4);
    stim[0] = mk_fcmp(2); stim[1] = NOP; stim[2] = mk_alu(6'h06);
    stim[3] = mk_stdf(); n_stim = 4;
    run_stream(40, "R6", "nop gap");
    for (int k = 0; k < 5; k++) begin
      logic [5:0] o;
      o = (k == 0) ? 6'h00 : (k == 1) ? 6'h01 : (k == 2) ? 6'h03 :
          (k == 3) ? 6'h25 : 6'h27;
      stim[0] = mk_fcmp(k % 4); stim[1] = mk_alu(o); stim[2] = mk_stdf();
      n_stim = 3;
      run_stream(0, "R6", $sformatf("middle op3 %h", o));
      chk(n_got == 3, "R6", "unlisted middle count", 32'(n_got), 3);
    end
    stim[0] = {2'b10, 5'd1, 6'h35, 5'd2, 9'h053, 5'd3};
    stim[1] = mk_alu(6'h02); stim[2] = mk_stdf(); n_stim = 3;
    run_stream(0, "R2", "other opf not compare");
    chk(n_got == 3, "R2", "other opf count", 32'(n_got), 3);

    // R7: back to back compares and repeated pairs
    stim[0] = mk_fcmp(0); stim[1] = mk_fcmp(3); stim[2] = mk_alu(6'h2A);
    stim[3] = mk_stdf(); n_stim = 4;
    run_stream(0, "R7", "cmp cmp op");
    chk(n_got == 5 && got[2] == NOP, "R7", "one NOP after second cmp", got[2], NOP);
    stim[0] = mk_fcmp(1); stim[1] = mk_alu(6'h12); stim[2] = mk_alu(6'h16);
    n_stim = 3;
    run_stream(0, "R7", "NOP clears history");
    chk(n_got == 4, "R7", "no second NOP", 32'(n_got), 4);

    // R8: flush together with a pending insertion
    n_got = 0;
    stim[0] = mk_fcmp(2); stim[1] = mk_alu(6'h32);
    step(1'b1, stim[0], 1'b1, 1'b0, acc);
    step(1'b0, 32'h0, 1'b1, 1'b0, acc);
    step(1'b1, stim[1], 1'b1, 1'b1, acc);
    chk(!acc, "R8", "in_ready low on flush", 32'(acc), 0);
    step(1'b1, stim[1], 1'b1, 1'b0, acc);
    chk(acc, "R8", "op taken after flush", 32'(acc), 1);
    step(1'b0, 32'h0, 1'b1, 1'b0, acc);
    chk(n_got == 2 && got[1] == stim[1], "R8", "no NOP across flush", got[1], stim[1]);

    // R8: flush discards a stalled staged word
    n_got = 0;
    step(1'b1, mk_fcmp(0), 1'b0, 1'b0, acc);
    step(1'b0, 32'h0, 1'b0, 1'b1, acc);
    step(1'b0, 32'h0, 1'b1, 1'b0, acc);
    step(1'b0, 32'h0, 1'b1, 1'b0, acc);
    chk(n_got == 0, "R8", "staged word dropped", 32'(n_got), 0);

    // R9: long random stream under back-pressure
    for (int r = 0; r < 3; r++) begin
      n_stim = 400;
      for (int i = 0; i < n_stim; i++) begin
        int s;
        s = $urandom % 6;
        stim[i] = (s < 2) ? mk_fcmp($urandom % 4) :
                  (s < 4) ? mk_alu(b_op3($urandom % 9)) :
                  (s == 4) ? mk_stdf() : mk_alu(6'h00);
      end
      run_stream(20 + 25 * r, "R9", $sformatf("random stream %0d", r));
    end

    n0 = 0;
    report();
  end

endmodule